// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Per-Channel Clock and Polarity Choice

This block produces four independent pulse-width-modulated outputs. Each channel runs an 8-bit up-counter that repeats over a programmable period. The output changes level when the counter reaches a programmable duty value. Each channel chooses its count clock in the shared control register. The first two channels use either clock A or a scaled clock S, and the last two use either clock B or clock S. Clock S is derived from clock A through a programmable prescaler. Clocks A and B arrive as one-cycle enable strobes in the system clock domain.

A per-channel polarity bit chooses the level that opens each period, called the lead level. The opposite level, called the trail level, follows once the duty count is reached. Period and duty values written over the bus are held in the bus registers. They are copied into the working copies only when the counter wraps, so a period never changes shape halfway through. A per-channel enable bit stops the channel, which then clears its counter and drives the lead level.

Each channel is a three-state machine: `CH_OFF`, `CH_LEAD` and `CH_TRAIL`.

| Transition | Condition |
|---|---|
| any state to `CH_OFF` | enable clear |
| `CH_OFF` to `CH_LEAD` or `CH_TRAIL` | enable set; the target is `CH_TRAIL` only if the duty value is zero; the new period starts at count 0 |
| `CH_LEAD` to `CH_TRAIL` | on a tick, the incremented count reaches the duty value |
| `CH_TRAIL` (or `CH_LEAD`) to `CH_LEAD` (or `CH_TRAIL` for duty zero) | on a tick at the last count, the counter wraps |
| any running state to itself | no tick |

Top module: `pwm4_clksel`

## Requirements
- R1: The bus map is as follows: address 0 is control, 1 is prescale, 2 is enable (bits 3:0 for channels 4..1), 4..7 are the period registers of channels 1..4, and 8..11 are the duty registers of channels 1..4. Control bits 7:4 select the clock for channels 4..1 and control bits 3:0 set the polarity for channels 4..1. Every register reads back its written value at any time. Unmapped addresses read 0.
- R2: After reset, every register reads 0 and every output is low.
- R3: With polarity 1, a channel is high from count 0 and goes low at the count equal to the duty value.
- R4: With polarity 0, a channel is low from count 0 and goes high at the count equal to the duty value.
- R5: A duty value of 0 gives the trail level for the whole period. A duty value equal to or above the period gives the lead level for the whole period.
- R6: The counter runs from 0 to period minus 1 and then wraps to 0. It advances only on a strobe of the channel's selected clock, so one period lasts the period value times the strobe spacing.
- R7: With clock select 0, channels 1 and 2 count on clock A and channels 3 and 4 count on clock B. With clock select 1, a channel counts on clock S.
- R8: Clock S gives one strobe per 2*(prescale+1) clock A strobes.
- R9: Period and duty values written while a channel runs take effect only at the next wrap.
- R10: While disabled, a channel holds its counter at 0 and drives its polarity bit. Enabling it starts a new period at count 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_a_en | input | 1 | Clock A strobe, one cycle wide |
| clk_b_en | input | 1 | Clock B strobe, one cycle wide |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pwm_out | output | 4 | Channel outputs, bit 0 is channel 1 |

## Verification
The bench uses the default 8-bit width and 4-bit address. Clock A is held high on every cycle, so channel counts line up one-to-one with clock cycles. This lets the pattern of each period be compared cycle by cycle for short periods. Clock B strobes every third cycle, which shows that a channel advances only on its own strobe. Small prescale values of 0 and 2 keep clock S gaps at 2 and 6 cycles, so both the clock-S formula and the clock-B spacing appear as distances between rising edges within a few dozen cycles.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
    localparam int NCH        = 4;
    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_PRESC = 1;
    localparam int ADDR_EN    = 2;
    localparam int ADDR_PER0  = 4;
    localparam int ADDR_DUTY0 = 8;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_LEAD  = 2'd1,
        CH_TRAIL = 2'd2
    } ch_state_t;
endpackage

// File: rtl/pwm4_prescale.sv
module pwm4_prescale #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_en,
    input  logic [CW-1:0] presc,
    output logic          s_en
);
    logic [CW-1:0] div_q;
    logic          half_q;

    // Divider reloads after presc+1 A strobes; every second reload emits S.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            half_q <= 1'b0;
            s_en   <= 1'b0;
        end else if (a_en) begin
            if (div_q >= presc) begin
                div_q  <= '0;
                half_q <= ~half_q;
                s_en   <= half_q;
            end else begin
                div_q  <= div_q + 1'b1;
                s_en   <= 1'b0;
            end
        end else begin
            s_en <= 1'b0;
        end
    end
endmodule

// File: rtl/pwm4_regs.sv
module pwm4_regs
    import pwm4_pkg::*;
#(
    parameter int CW = 8,
    parameter int AW = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           addr,
    input  logic [CW-1:0]           wdata,
    output logic [CW-1:0]           rdata,
    output logic [2*NCH-1:0]        ctrl_q,
    output logic [CW-1:0]           presc_q,
    output logic [NCH-1:0]          en_q,
    output logic [NCH-1:0][CW-1:0]  per_q,
    output logic [NCH-1:0][CW-1:0]  duty_q
);
    int unsigned a_idx;
    assign a_idx = 32'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            presc_q <= '0;
            en_q    <= '0;
            per_q   <= '0;
            duty_q  <= '0;
        end else if (we) begin
            if (a_idx == ADDR_CTRL)  ctrl_q  <= wdata[2*NCH-1:0];
            if (a_idx == ADDR_PRESC) presc_q <= wdata;
            if (a_idx == ADDR_EN)    en_q    <= wdata[NCH-1:0];
            for (int i = 0; i < NCH; i++) begin
                if (a_idx == ADDR_PER0 + i)  per_q[i]  <= wdata;
                if (a_idx == ADDR_DUTY0 + i) duty_q[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (a_idx == ADDR_CTRL)  rdata = CW'(ctrl_q);
        if (a_idx == ADDR_PRESC) rdata = presc_q;
        if (a_idx == ADDR_EN)    rdata = CW'(en_q);
        for (int i = 0; i < NCH; i++) begin
            if (a_idx == ADDR_PER0 + i)  rdata = per_q[i];
            if (a_idx == ADDR_DUTY0 + i) rdata = duty_q[i];
        end
    end
endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan
    import pwm4_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic          pol,
    input  logic [CW-1:0] per_reg,
    input  logic [CW-1:0] duty_reg,
    output logic          pwm
);
    ch_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] per_q, per_d;
    logic [CW-1:0] duty_q, duty_d;
    logic [CW-1:0] cnt_inc;
    logic          wrap;

    assign cnt_inc = cnt_q + 1'b1;
    // A period of 0 behaves as a period of 1.
    assign wrap    = (per_q == '0) || (cnt_inc >= per_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
            cnt_q   <= '0;
            per_q   <= '0;
            duty_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            per_q   <= per_d;
            duty_q  <= duty_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        per_d   = per_q;
        duty_d  = duty_q;
        if (!en) begin
            state_d = CH_OFF;
            cnt_d   = '0;
            per_d   = per_reg;
            duty_d  = duty_reg;
        end else begin
            unique case (state_q)
                CH_OFF: begin
                    cnt_d   = '0;
                    per_d   = per_reg;
                    duty_d  = duty_reg;
                    state_d = (duty_reg == '0) ? CH_TRAIL : CH_LEAD;
                end
                CH_LEAD, CH_TRAIL: begin
                    if (tick) begin
                        if (wrap) begin
                            cnt_d   = '0;
                            per_d   = per_reg;
                            duty_d  = duty_reg;
                            state_d = (duty_reg == '0) ? CH_TRAIL : CH_LEAD;
                        end else begin
                            cnt_d   = cnt_inc;
                            state_d = (cnt_inc >= duty_q) ? CH_TRAIL : CH_LEAD;
                        end
                    end
                end
                default: state_d = CH_OFF;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            CH_TRAIL: pwm = ~pol;
            default:  pwm = pol;
        endcase
    end
endmodule

// File: rtl/pwm4_clksel.sv
module pwm4_clksel
    import pwm4_pkg::*;
#(
    parameter int CW = 8,
    parameter int AW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clk_a_en,
    input  logic           clk_b_en,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [CW-1:0]  bus_wdata,
    output logic [CW-1:0]  bus_rdata,
    output logic [NCH-1:0] pwm_out
);
    localparam int N_ON_A = NCH / 2;

    logic [2*NCH-1:0]       ctrl;
    logic [CW-1:0]          presc;
    logic [NCH-1:0]         en;
    logic [NCH-1:0][CW-1:0] per;
    logic [NCH-1:0][CW-1:0] duty;
    logic                   s_en;

    pwm4_regs #(.CW(CW), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .ctrl_q  (ctrl),
        .presc_q (presc),
        .en_q    (en),
        .per_q   (per),
        .duty_q  (duty)
    );

    pwm4_prescale #(.CW(CW)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .a_en  (clk_a_en),
        .presc (presc),
        .s_en  (s_en)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic base_en;
        logic tick;
        if (g < N_ON_A) begin : g_base_a
            assign base_en = clk_a_en;
        end else begin : g_base_b
            assign base_en = clk_b_en;
        end
        assign tick = ctrl[NCH+g] ? s_en : base_en;

        pwm4_chan #(.CW(CW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .en       (en[g]),
            .pol      (ctrl[g]),
            .per_reg  (per[g]),
            .duty_reg (duty[g]),
            .pwm      (pwm_out[g])
        );
    end
endmodule

// File: rtl/pwm4_chan_sva.sv
module pwm4_chan_sva
    import pwm4_pkg::*;
#(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          en,
    input logic          pol,
    input logic          pwm,
    input ch_state_t     state_q,
    input logic [CW-1:0] cnt_q,
    input logic [CW-1:0] per_q,
    input logic [CW-1:0] duty_q
);
    // R6: the count never leaves the latched period
    a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q == '0) ? (cnt_q == '0) : (cnt_q < per_q));

    // R6: no strobe, no movement
    a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick && state_q != CH_OFF) |=> $stable(cnt_q));

    // R10: a disabled channel clears its counter and parks
    a_r10_disabled_cnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0 && state_q == CH_OFF));

    // R10: output follows the polarity bit once disabled
    a_r10_disabled_level: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en) |-> (pwm == pol));

    // R5: zero duty keeps the trail level while running
    a_r5_duty_zero_trail: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CH_OFF && duty_q == '0) |-> (pwm == !pol));
endmodule

bind pwm4_chan pwm4_chan_sva #(.CW(CW)) u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .en      (en),
    .pol     (pol),
    .pwm     (pwm),
    .state_q (state_q),
    .cnt_q   (cnt_q),
    .per_q   (per_q),
    .duty_q  (duty_q)
);

// File: tb/pwm4_clksel_tb.sv
module pwm4_clksel_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_a_en = 1'b0;
    logic       clk_b_en = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm4_clksel u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_a_en  (clk_a_en),
        .clk_b_en  (clk_b_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    // vector: period, duty, polarity (channel 1, clock A every cycle)
    localparam logic [23:0] VEC [6] = '{
        {8'd5, 8'd2, 8'd1},
        {8'd5, 8'd2, 8'd0},
        {8'd4, 8'd0, 8'd1},
        {8'd4, 8'd4, 8'd0},
        {8'd3, 8'd9, 8'd1},
        {8'd8, 8'd7, 8'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = 4'(a);
        bus_wdata = 8'(d);
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        bus_addr = 4'(a);
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic rise_gap(input int ch, output int gap);
        logic prev;
        int   cyc;
        bit   seen;
        gap  = -1;
        cyc  = 0;
        seen = 1'b0;
        @(negedge clk);
        prev = pwm_out[ch];
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            cyc++;
            if (!prev && pwm_out[ch]) begin
                if (seen) begin
                    gap = cyc;
                    break;
                end
                seen = 1'b1;
                cyc  = 0;
            end
            prev = pwm_out[ch];
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // clock B: one strobe every third cycle
    initial begin
        int bcnt;
        bcnt = 0;
        forever begin
            @(negedge clk);
            bcnt     = (bcnt == 2) ? 0 : bcnt + 1;
            clk_b_en = (bcnt == 0);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        int v;
        int g;
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2 outputs after reset", int'(pwm_out), 0);
        rd(0, v);
        check("R2 control after reset", v, 0);
        rst_n = 1'b1;
        clk_a_en = 1'b1;

        // R1: readback and map
        wr(0, 8'hA5);
        rd(0, v);
        check("R1 control readback", v, 8'hA5);
        wr(6, 8'h5A);
        rd(6, v);
        check("R1 period ch3 readback", v, 8'h5A);
        rd(3, v);
        check("R1 unmapped reads zero", v, 0);
        wr(0, 0);

        // R3 R4 R5 R6 R10: vector table on channel 1
        for (int n = 0; n < 6; n++) begin
            int p;
            int d;
            int pl;
            int bad;
            p   = int'(VEC[n][23:16]);
            d   = int'(VEC[n][15:8]);
            pl  = int'(VEC[n][7:0]);
            bad = 0;
            wr(2, 0);
            wr(4, p);
            wr(8, d);
            wr(0, pl);
            check("R10 disabled drives polarity", int'(pwm_out[0]), pl);
            wr(2, 1);
            for (int i = 0; i < 2 * p; i++) begin
                int e;
                @(negedge clk);
                e = ((i % p) < d) ? pl : 1 - pl;
                if (int'(pwm_out[0]) != e) bad++;
            end
            check($sformatf("R3/R4/R5/R6 pattern vec %0d mismatches", n), bad, 0);
        end
        wr(2, 0);

        // R8: clock S on channel 1, prescale 2 -> strobe every 6 cycles
        wr(1, 2);
        wr(4, 2);
        wr(8, 1);
        wr(0, 8'h11);
        wr(2, 1);
        rise_gap(0, g);
        check("R8 clock S gap prescale 2", g, 12);
        wr(2, 0);

        // R7: channel 3 on clock B
        wr(6, 2);
        wr(10, 1);
        wr(0, 8'h00);
        wr(2, 4);
        rise_gap(2, g);
        check("R7 channel 3 on clock B", g, 6);
        // R7 R8: channel 3 on clock S, prescale 0
        wr(1, 0);
        wr(0, 8'h40);
        rise_gap(2, g);
        check("R7 channel 3 on clock S", g, 4);
        wr(2, 0);

        // R9: shadowed duty on channel 2
        wr(5, 8);
        wr(9, 4);
        wr(0, 8'h02);
        wr(2, 2);
        begin
            logic prev;
            @(negedge clk);
            prev = pwm_out[1];
            for (int k = 0; k < 50; k++) begin
                @(negedge clk);
                if (!prev && pwm_out[1]) break;
                prev = pwm_out[1];
            end
        end
        wr(9, 1);
        @(negedge clk);
        check("R9 old duty kept mid period", int'(pwm_out[1]), 1);
        repeat (5) @(negedge clk);
        check("R9 next period starts lead", int'(pwm_out[1]), 1);
        @(negedge clk);
        check("R9 new duty after wrap", int'(pwm_out[1]), 0);
        wr(2, 0);

        // R10: disabled channel 4 follows polarity
        wr(0, 8'h08);
        check("R10 disabled ch4 high", int'(pwm_out[3]), 1);
        wr(0, 8'h00);
        check("R10 disabled ch4 low", int'(pwm_out[3]), 0);

        done = 1'b1;
        report();
    end
endmodule